// File: doc/BRIEF.md
# Training Word Inserter for a Parallel-to-Serial Link

This block sits ahead of a serializer and picks, on every word clock, what the serializer gets. It either passes the user's 18-bit parallel word straight through or substitutes a fixed training word. The receiver needs that training word to find the word boundary within a known number of cycles. The training word puts one rising and one falling transition on the line per word: nine ones, then nine zeros.

Training starts on a request input, and the request has to pass a pulse-width filter first. Once a request qualifies, the block sends a burst of exactly 1026 training words. A request that is still high when the burst ends keeps training running until it drops. This means the remote receiver's "not locked" indication can drive the request directly.

An enable input puts the block in a powered-down state. In that state the output word is zero and the drive flag is low, which marks the serial line as undriven. A flag reports each cycle in which a training word is on the output.

Top module: `sync_sender`

## Requirements
- R1: During reset and after it, with enable high and no request, `train_o` is 0, `drive_o` is 1 and `word_o` equals `data_i`.
- R2: While `train_o` is 1, `word_o` is 18'h3FE00: bits 17 down to 9 are ones and bits 8 down to 0 are zeros, and bit 17 is sent first.
- R3: While `train_o` is 0 and enable is high, `word_o` equals `data_i` in the same cycle.
- R4: A request that is sampled high on 6 or fewer consecutive rising edges starts no training.
- R5: A request sampled high on 7 consecutive rising edges qualifies. `train_o` goes to 1 right after the 7th of those edges.
- R6: If the request is low at the burst's last word, a qualified request gives exactly 1026 consecutive cycles with `train_o` high.
- R7: A request that rises and qualifies again while a burst is running neither restarts nor lengthens that burst.
- R8: If the request is high during the 1026th training word, training continues. `train_o` falls right after the first rising edge at which the request is sampled low.
- R9: While `en_i` is 0, `word_o` is 0 and both `drive_o` and `train_o` are 0. A burst that is running is abandoned.
- R10: After `en_i` returns high, the block sends user data. A request that was held high through the power-down has to be sampled high on 7 edges with enable high before training starts.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low selects power-down |
| sync_req_i | input | 1 | Training request, filtered by width |
| data_i | input | 18 | User parallel word |
| word_o | output | 18 | Word handed to the serializer |
| train_o | output | 1 | High while a training word is sent |
| drive_o | output | 1 | High when the serial line should be driven |

## Verification
The assertions assume that `en_i` and `sync_req_i` are synchronous to the word clock and settle before each rising edge. They also assume the request is only a level whose consecutive high samples matter, with no meaning given to glitches between edges. The stimulus respects this by changing every input only on the falling clock edge. It also starts each scenario from an idle state, with the request low and no burst running. That gives every width-filter run and every burst count a known starting cycle. The expected training window for each scenario is derived from those start cycles and the request pattern.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned WORD_W    = 18;
  localparam int unsigned MIN_PULSE = 6;     // request must exceed this many edges
  localparam int unsigned BURST_LEN = 1026;
endpackage

// File: rtl/ssp_req_filter.sv
module ssp_req_filter #(
  parameter int unsigned MIN_PULSE = ssp_pkg::MIN_PULSE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic req_i,
  output logic qual_o
);
  localparam int unsigned SAT = MIN_PULSE + 1;
  localparam int unsigned CW  = $clog2(SAT + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                run_q <= '0;
    else if (!en_i || !req_i)   run_q <= '0;
    else if (run_q != CW'(SAT)) run_q <= run_q + 1'b1;
  end

  // single-cycle qualify on the edge that completes the run
  assign qual_o = en_i && req_i && (run_q == CW'(MIN_PULSE));

  AST_QUAL_NEEDS_HISTORY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_o |-> ($past(req_i) && $past(en_i))); // R5
  AST_FRESH_REQ_NO_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_i) |-> !qual_o); // R4
endmodule

// File: rtl/ssp_burst_ctrl.sv
module ssp_burst_ctrl #(
  parameter int unsigned BURST_LEN = ssp_pkg::BURST_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic qual_i,
  input  logic req_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(BURST_LEN);
  localparam logic [CW-1:0] LAST = CW'(BURST_LEN - 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!en_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      if (qual_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (!req_i) begin
      // burst done and request released
      active_q <= 1'b0;
      cnt_q    <= '0;
    end
  end

  assign active_o = active_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R6
  AST_NO_EARLY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && active_q && cnt_q != LAST) |=> active_q); // R6
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && active_q && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R7
  AST_HELD_EXTENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && active_q && cnt_q == LAST && req_i) |=> active_q); // R8
  AST_IDLE_NEEDS_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !qual_i) |=> !active_q); // R4
  AST_OFF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !active_q); // R9
endmodule

// File: rtl/ssp_word_sel.sv
module ssp_word_sel #(
  parameter int unsigned WORD_W = ssp_pkg::WORD_W
) (
  input  logic              en_i,
  input  logic              active_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o,
  output logic              train_o,
  output logic              drive_o
);
  localparam int unsigned HALF = WORD_W / 2;

  logic [WORD_W-1:0] pattern;

  // upper half ones, lower half zeros
  for (genvar g = 0; g < WORD_W; g++) begin : g_pat
    assign pattern[g] = (g >= HALF);
  end

  always_comb begin
    if (!en_i)         word_o = '0;
    else if (active_i) word_o = pattern;
    else               word_o = data_i;
  end

  assign train_o = en_i && active_i;
  assign drive_o = en_i;
endmodule

// File: rtl/sync_sender.sv
module sync_sender #(
  parameter int unsigned WORD_W    = ssp_pkg::WORD_W,
  parameter int unsigned MIN_PULSE = ssp_pkg::MIN_PULSE,
  parameter int unsigned BURST_LEN = ssp_pkg::BURST_LEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sync_req_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o,
  output logic              train_o,
  output logic              drive_o
);
  localparam int unsigned HALF = WORD_W / 2;

  logic qual;
  logic active;

  ssp_req_filter #(.MIN_PULSE(MIN_PULSE)) u_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .req_i  (sync_req_i),
    .qual_o (qual)
  );

  ssp_burst_ctrl #(.BURST_LEN(BURST_LEN)) u_burst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .qual_i   (qual),
    .req_i    (sync_req_i),
    .active_o (active)
  );

  ssp_word_sel #(.WORD_W(WORD_W)) u_sel (
    .en_i     (en_i),
    .active_i (active),
    .data_i   (data_i),
    .word_o   (word_o),
    .train_o  (train_o),
    .drive_o  (drive_o)
  );

  AST_TRAIN_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_o |-> ((&word_o[WORD_W-1:HALF]) && !(|word_o[HALF-1:0]))); // R2
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (word_o == '0 && !train_o && !drive_o)); // R9
  AST_WAKE_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> !train_o); // R10
  AST_PASS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !train_o) |-> (word_o == data_i)); // R3
endmodule

// File: tb/sim_sync_sender.sv
module sim_sync_sender;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b1;
  logic         req = 1'b0;
  logic [W-1:0] data = '0;
  logic [W-1:0] word;
  logic         train;
  logic         drive;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W-1:0] exp_word_q[$];
  logic         exp_train_q[$];
  logic         exp_drive_q[$];
  string        tag_q[$];

  // R2: nine ones above nine zeros
  localparam logic [W-1:0] TRAIN_W = {{(W/2){1'b1}}, {(W/2){1'b0}}};

  always #5 clk = ~clk;

  sync_sender u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sync_req_i(req),
    .data_i(data), .word_o(word), .train_o(train), .drive_o(drive)
  );

  task automatic check(string tag, logic [W-1:0] ew, logic et, logic ed);
    checks++;
    if (word !== ew || train !== et || drive !== ed) begin
      fails++;
      $display("FAIL %s: word=%h train=%b drive=%b expected word=%h train=%b drive=%b",
               tag, word, train, drive, ew, et, ed);
    end
  endtask

  // monitor: compare just before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (exp_word_q.size() > 0)
        check(tag_q.pop_front(), exp_word_q.pop_front(),
              exp_train_q.pop_front(), exp_drive_q.pop_front());
    end
  end

  // driver: one word per cycle; cycle k is driven at the k-th falling edge
  task automatic scenario(string tag, int total, int r1_on, int r1_len,
                          int r2_on, int r2_len, int off_from, int off_len,
                          int tr_from, int tr_to);
    for (int k = 0; k < total; k++) begin
      logic on, r, t;
      logic [W-1:0] ew;
      @(negedge clk);
      on = !(k >= off_from && k < off_from + off_len);
      r  = (k >= r1_on && k < r1_on + r1_len) || (k >= r2_on && k < r2_on + r2_len);
      t  = on && (k >= tr_from && k <= tr_to);
      en   = on;
      req  = r;
      data = W'($urandom);
      ew   = !on ? '0 : (t ? TRAIN_W : data);
      exp_word_q.push_back(ew);
      exp_train_q.push_back(t);
      exp_drive_q.push_back(on);
      tag_q.push_back(tag);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    data = 18'h2A5A5;
    #23;
    check("R1 in reset", 18'h2A5A5, 1'b0, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    scenario("R1", 10, -1, 0, -1, 0, -1, 0, 1, 0);
    scenario("R4 width 6", 30, 0, 6, -1, 0, -1, 0, 1, 0);
    scenario("R4 width 1", 20, 0, 1, 5, 3, -1, 0, 1, 0);
    scenario("R5 R6 R2 R3 width 7", 1045, 0, 7, -1, 0, -1, 0, 7, 1032);
    scenario("R7 requalify", 1045, 0, 10, 500, 20, -1, 0, 7, 1032);
    scenario("R8 held", 1215, 0, 1200, -1, 0, -1, 0, 7, 1200);
    scenario("R9 off mid-burst", 130, 0, 7, -1, 0, 100, 5, 7, 99);
    scenario("R10 wake", 1050, 0, 14, -1, 0, 0, 4, 11, 1036);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule